// File: doc/BRIEF.md
# Six-Tap Packed-Coefficient Multiply-Accumulate Lane

This block is a single 32-bit lane of a vector multiply-accumulate datapath for small two-dimensional filter kernels. It accepts two 32-bit words of unsigned pixel bytes and two 32-bit words of packed signed coefficients. Each coefficient word holds three 10-bit signed taps. The lane forms unsigned-byte by signed-tap products and reduces them into two signed 32-bit result words.

A 2-bit selector has two jobs. It chooses which pixel bytes feed the taps, and it chooses which result word receives the six-product sum and which receives the three-product sum. A direction input switches between vertical and horizontal byte routing. An accumulate input chooses whether the sums replace the held results or are added to them. Operands are taken on a valid strobe and the results appear registered one cycle later.

Top module: `lane_mac_top`

## Requirements
- R1: Each coefficient word yields taps t0, t1, t2. Tap p is a signed 10-bit value. Its low 8 bits are word bits [8p+7:8p] and its top 2 bits are word bits [25+2p:24+2p], sign-extended, so a tap spans -512..511.
- R2: Each product is an unsigned pixel byte times a signed tap. All sums and accumulations are 32-bit two's complement and wrap modulo 2^32 with no saturation.
- R3: With `horiz`=0 and `sel`[1]=0, the A triple is (P0.b3, P1.b2, P1.b3) and the B triple is (P0.b1, P1.b0, P1.b1). With `horiz`=0 and `sel`[1]=1, A is (P0.b2, P0.b3, P1.b2) and B is (P0.b0, P0.b1, P1.b0). P0 is `pix_lo`, P1 is `pix_hi`, and bN is bits [8N+7:8N].
- R4: With `horiz`=1 and `sel`[1]=0, A is (P1.b3, P1.b1, P0.b3) and B is (P1.b2, P1.b0, P0.b2). With `horiz`=1 and `sel`[1]=1, A is (P1.b1, P0.b3, P0.b1) and B is (P1.b0, P0.b2, P0.b0).
- R5: When `sel`[0]=0, `res_hi` takes A·K1 + B·K0 and `res_lo` takes B·K1. K0 is the tap triple of `coef_lo` and K1 is the tap triple of `coef_hi`, each in position order 0, 1, 2.
- R6: When `sel`[0]=1, `res_lo` takes A·K1 + B·K0 and `res_hi` takes A·K0.
- R7: With `accum`=0, an accepted operand set replaces both result words with the new sums.
- R8: With `accum`=1, an accepted operand set adds the new sums to the held value of each result word.
- R9: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high. While `in_valid` is low, both result words hold their value.
- R10: A synchronous active-high reset clears `out_valid`, `res_lo` and `res_hi` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| pix_lo | input | 32 | Pixel word P0 |
| pix_hi | input | 32 | Pixel word P1 |
| coef_lo | input | 32 | Packed coefficient word K0 |
| coef_hi | input | 32 | Packed coefficient word K1 |
| sel | input | 2 | Routing and long-sum placement selector |
| horiz | input | 1 | 1 = horizontal routing, 0 = vertical |
| accum | input | 1 | 1 = add to held results, 0 = overwrite |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| res_lo | output | 32 | Result word 0 |
| res_hi | output | 32 | Result word 1 |

## Verification
The bench puts every stimulus vector through all eight direction/selector combinations.

- A swapped byte in a routing table shows up as a wrong sum in exactly one combination.
- Confusing the two selector bits moves the long sum to the wrong result word.
- Isolated taps at -512 and +511 catch a sign field taken from the wrong bit pair, and they catch a field that is zero-extended instead of sign-extended.
- A long run of accumulations with maximum-magnitude operands pushes the result past 2^31. A saturating or narrowed adder would fail that check.

Further checks target the cycles where `in_valid` is low, back-to-back strobes, and a reset issued mid-run.

// File: rtl/lane_mac_pkg.sv
package lane_mac_pkg;
    parameter int WORD_W = 32;
    parameter int BYTE_W = 8;
    parameter int TAPS   = 3;
    parameter int SGN_W  = 2;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] hi;
    } lane_state_t;
endpackage

// File: rtl/coef_unpack.sv
module coef_unpack #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    parameter int TAPS   = 3,
    parameter int SGN_W  = 2
) (
    input  logic [WORD_W-1:0]               word_i,
    output logic [TAPS*(BYTE_W+SGN_W)-1:0]  taps_o
);
    localparam int CW       = BYTE_W + SGN_W;
    localparam int SGN_BASE = WORD_W - BYTE_W;

    // the sign field is the tap MSB pair, so the 10-bit value is already signed
    for (genvar p = 0; p < TAPS; p++) begin : g_tap
        assign taps_o[p*CW +: CW] = {word_i[SGN_BASE + SGN_W*p +: SGN_W],
                                     word_i[BYTE_W*p +: BYTE_W]};
    end
endmodule

// File: rtl/pixel_router.sv
module pixel_router #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    parameter int TAPS   = 3
) (
    input  logic [WORD_W-1:0]      p0_i,
    input  logic [WORD_W-1:0]      p1_i,
    input  logic                   horiz_i,
    input  logic                   upper_i,
    output logic [TAPS*BYTE_W-1:0] tri_a_o,
    output logic [TAPS*BYTE_W-1:0] tri_b_o
);
    // byte n of a pixel word
    function automatic logic [BYTE_W-1:0] bsel(input logic [WORD_W-1:0] w, input int n);
        return w[n*BYTE_W +: BYTE_W];
    endfunction

    // triples are packed with tap 0 in the low byte
    always_comb begin
        unique case ({horiz_i, upper_i})
            2'b00: begin
                tri_a_o = {bsel(p1_i, 3), bsel(p1_i, 2), bsel(p0_i, 3)};
                tri_b_o = {bsel(p1_i, 1), bsel(p1_i, 0), bsel(p0_i, 1)};
            end
            2'b01: begin
                tri_a_o = {bsel(p1_i, 2), bsel(p0_i, 3), bsel(p0_i, 2)};
                tri_b_o = {bsel(p1_i, 0), bsel(p0_i, 1), bsel(p0_i, 0)};
            end
            2'b10: begin
                tri_a_o = {bsel(p0_i, 3), bsel(p1_i, 1), bsel(p1_i, 3)};
                tri_b_o = {bsel(p0_i, 2), bsel(p1_i, 0), bsel(p1_i, 2)};
            end
            default: begin
                tri_a_o = {bsel(p0_i, 1), bsel(p0_i, 3), bsel(p1_i, 1)};
                tri_b_o = {bsel(p0_i, 0), bsel(p0_i, 2), bsel(p1_i, 0)};
            end
        endcase
    end
endmodule

// File: rtl/dot3.sv
module dot3 #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    parameter int TAPS   = 3,
    parameter int SGN_W  = 2
) (
    input  logic [TAPS*BYTE_W-1:0]          px_i,
    input  logic [TAPS*(BYTE_W+SGN_W)-1:0]  cf_i,
    output logic [WORD_W-1:0]               sum_o
);
    localparam int CW = BYTE_W + SGN_W;
    localparam int PW = BYTE_W + 1 + CW;

    logic [WORD_W-1:0] term [TAPS];

    for (genvar k = 0; k < TAPS; k++) begin : g_mul
        logic signed [PW-1:0] a_ext, c_ext, prod;
        assign a_ext = {{(PW-BYTE_W){1'b0}}, px_i[k*BYTE_W +: BYTE_W]};
        assign c_ext = {{(PW-CW){cf_i[k*CW + CW-1]}}, cf_i[k*CW +: CW]};
        assign prod  = a_ext * c_ext;
        assign term[k] = {{(WORD_W-PW){prod[PW-1]}}, prod};
    end

    always_comb begin
        sum_o = '0;
        for (int k = 0; k < TAPS; k++) sum_o = sum_o + term[k];
    end
endmodule

// File: rtl/lane_mac_top.sv
module lane_mac_top
    import lane_mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] pix_lo,
    input  logic [WORD_W-1:0] pix_hi,
    input  logic [WORD_W-1:0] coef_lo,
    input  logic [WORD_W-1:0] coef_hi,
    input  logic [1:0]        sel,
    input  logic              horiz,
    input  logic              accum,
    output logic              out_valid,
    output logic [WORD_W-1:0] res_lo,
    output logic [WORD_W-1:0] res_hi
);
    localparam int CW  = BYTE_W + SGN_W;
    localparam int TBW = TAPS * BYTE_W;
    localparam int TCW = TAPS * CW;

    logic [TCW-1:0]    k0, k1, short_cf;
    logic [TBW-1:0]    tri_a, tri_b, short_px;
    logic [WORD_W-1:0] ak1, bk0, short_sum, long_sum, lo_sum, hi_sum;
    lane_state_t       st_d, st_q;

    coef_unpack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .TAPS(TAPS), .SGN_W(SGN_W))
        i_unpack0 (.word_i(coef_lo), .taps_o(k0));
    coef_unpack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .TAPS(TAPS), .SGN_W(SGN_W))
        i_unpack1 (.word_i(coef_hi), .taps_o(k1));

    pixel_router #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .TAPS(TAPS))
        i_route (.p0_i(pix_lo), .p1_i(pix_hi), .horiz_i(horiz), .upper_i(sel[1]),
                 .tri_a_o(tri_a), .tri_b_o(tri_b));

    // the long sum is the same for both parities; only the short one moves
    assign short_px = sel[0] ? tri_a : tri_b;
    assign short_cf = sel[0] ? k0    : k1;

    dot3 #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .TAPS(TAPS), .SGN_W(SGN_W))
        i_dot_ak1 (.px_i(tri_a), .cf_i(k1), .sum_o(ak1));
    dot3 #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .TAPS(TAPS), .SGN_W(SGN_W))
        i_dot_bk0 (.px_i(tri_b), .cf_i(k0), .sum_o(bk0));
    dot3 #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .TAPS(TAPS), .SGN_W(SGN_W))
        i_dot_short (.px_i(short_px), .cf_i(short_cf), .sum_o(short_sum));

    assign long_sum = ak1 + bk0;
    assign lo_sum   = sel[0] ? long_sum  : short_sum;
    assign hi_sum   = sel[0] ? short_sum : long_sum;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.lo = accum ? st_q.lo + lo_sum : lo_sum;
            st_d.hi = accum ? st_q.hi + hi_sum : hi_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign res_lo    = st_q.lo;
    assign res_hi    = st_q.hi;
endmodule

// File: rtl/lane_mac_chk.sv
module lane_mac_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] coef_lo,
    input logic [31:0] coef_hi,
    input logic        accum,
    input logic        out_valid,
    input logic [31:0] res_lo,
    input logic [31:0] res_hi
);
    assert_strobe_follows_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_strobe_drops_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res_lo) && $stable(res_hi)));
    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!out_valid && res_lo == 32'd0 && res_hi == 32'd0));
    assert_overwrite_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !accum && coef_lo == 32'd0 && coef_hi == 32'd0)
        |=> (res_lo == 32'd0 && res_hi == 32'd0));
    assert_accum_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && accum && coef_lo == 32'd0 && coef_hi == 32'd0)
        |=> ($stable(res_lo) && $stable(res_hi)));
endmodule

bind lane_mac_top lane_mac_chk i_chk (.*);

// File: tb/test_lane_mac_top.sv
module test_lane_mac_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] u0, u1, w0, w1;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'h0403_0201, 32'h0807_0605, 32'h0003_0201, 32'h0006_0504},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h2A00_0000, 32'h2A00_0000},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h15FF_FFFF, 32'h15FF_FFFF},
        '{32'h1234_5678, 32'h9ABC_DEF0, 32'h3F80_7F01, 32'h0C11_2233},
        '{32'h8000_0080, 32'h0080_8000, 32'h2110_F00F, 32'h0AFE_01FF},
        '{32'h0000_0001, 32'h0100_0000, 32'h0000_0001, 32'h0100_0000},
        '{32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h1B5A_A55A, 32'h24C3_3CC3},
        '{32'h7F80_FF01, 32'h01FF_807F, 32'h3FFF_FFFF, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] pix_lo = '0, pix_hi = '0, coef_lo = '0, coef_hi = '0;
    logic [1:0]  sel = '0;
    logic        horiz = 1'b0, accum = 1'b0;
    logic        out_valid;
    logic [31:0] res_lo, res_hi;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_mac_top i_lane_mac_top (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int tap(input logic [31:0] w, input int p);
        logic signed [9:0] v;
        v = {w[24 + 2*p +: 2], w[8*p +: 8]};
        return int'(v);
    endfunction

    function automatic int bt(input logic [31:0] w, input int n);
        return int'({24'd0, w[8*n +: 8]});
    endfunction

    task automatic model(input vec_t v, input logic hz, input logic [1:0] s,
                         output logic [31:0] lo, output logic [31:0] hi);
        int a [3];
        int b [3];
        int ak1, bk0, bk1, ak0;
        case ({hz, s[1]})
            2'b00: begin a = '{bt(v.u0,3), bt(v.u1,2), bt(v.u1,3)}; b = '{bt(v.u0,1), bt(v.u1,0), bt(v.u1,1)}; end
            2'b01: begin a = '{bt(v.u0,2), bt(v.u0,3), bt(v.u1,2)}; b = '{bt(v.u0,0), bt(v.u0,1), bt(v.u1,0)}; end
            2'b10: begin a = '{bt(v.u1,3), bt(v.u1,1), bt(v.u0,3)}; b = '{bt(v.u1,2), bt(v.u1,0), bt(v.u0,2)}; end
            default: begin a = '{bt(v.u1,1), bt(v.u0,3), bt(v.u0,1)}; b = '{bt(v.u1,0), bt(v.u0,2), bt(v.u0,0)}; end
        endcase
        ak1 = 0; bk0 = 0; bk1 = 0; ak0 = 0;
        for (int k = 0; k < 3; k++) begin
            ak1 += a[k] * tap(v.w1, k);
            bk0 += b[k] * tap(v.w0, k);
            bk1 += b[k] * tap(v.w1, k);
            ak0 += a[k] * tap(v.w0, k);
        end
        if (!s[0]) begin hi = ak1 + bk0; lo = bk1; end
        else       begin lo = ak1 + bk0; hi = ak0; end
    endtask

    // drive at negedge, result registered at the next posedge, sample at the following negedge
    task automatic issue(input vec_t v, input logic hz, input logic [1:0] s, input logic acc);
        pix_lo = v.u0; pix_hi = v.u1; coef_lo = v.w0; coef_hi = v.w1;
        horiz = hz; sel = s; accum = acc; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] elo, ehi, slo, shi;
        vec_t v;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset valid", {31'd0, out_valid}, 32'd0);
        check("R10 reset lo", res_lo, 32'd0);
        check("R10 reset hi", res_hi, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // table walk: R3 R4 R5 R6 R7 across all routing combinations
        foreach (VECS[i]) begin
            for (int m = 0; m < 8; m++) begin
                issue(VECS[i], m[2], m[1:0], 1'b0);
                model(VECS[i], m[2], m[1:0], elo, ehi);
                check(m[2] ? "R4 lo" : "R3 lo", res_lo, elo);
                check(m[0] ? "R6 hi" : "R5 hi", res_hi, ehi);
                check("R9 valid", {31'd0, out_valid}, 32'd1);
            end
        end

        // R1 tap 0 of coef_hi at -512
        v = '{32'h0000_0100, 32'h0, 32'h0, 32'h0200_0000};
        issue(v, 1'b0, 2'd0, 1'b0);
        check("R1 neg tap lo", res_lo, 32'hFFFF_FE00);
        check("R1 neg tap hi", res_hi, 32'h0);
        // R1 tap 2 of coef_hi at +511
        v = '{32'h0, 32'h0000_FF00, 32'h0, 32'h10FF_0000};
        issue(v, 1'b0, 2'd0, 1'b0);
        check("R1 max tap lo", res_lo, 32'h0001_FD01);
        check("R1 max tap hi", res_hi, 32'h0);

        // R8 accumulate doubles; R7 overwrite then restores
        issue(v, 1'b0, 2'd0, 1'b1);
        check("R8 accumulate lo", res_lo, 32'h0003_FA02);
        issue(v, 1'b0, 2'd0, 1'b0);
        check("R7 overwrite lo", res_lo, 32'h0001_FD01);

        // R9 idle hold with changing inputs
        pix_lo = 32'hFFFF_FFFF; coef_hi = 32'h15FF_FFFF; accum = 1'b1;
        @(negedge clk);
        check("R9 idle valid", {31'd0, out_valid}, 32'd0);
        check("R9 idle hold lo", res_lo, 32'h0001_FD01);
        check("R9 idle hold hi", res_hi, 32'h0);

        // R10 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 midrun lo", res_lo, 32'h0);

        // R2 back-to-back accumulation past 2^31 with wrap
        v = VECS[2];
        slo = '0; shi = '0;
        pix_lo = v.u0; pix_hi = v.u1; coef_lo = v.w0; coef_hi = v.w1;
        horiz = 1'b0; sel = 2'd1; accum = 1'b1; in_valid = 1'b1;
        model(v, 1'b0, 2'd1, elo, ehi);
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            slo = slo + elo; shi = shi + ehi;
        end
        in_valid = 1'b0;
        check("R2 wrap lo", res_lo, slo);
        check("R2 wrap hi", res_hi, shi);
        check("R2 wrapped negative", {31'd0, res_lo[31]}, 32'd1);
        @(negedge clk);
        check("R9 drop after burst", {31'd0, out_valid}, 32'd0);

        finish_run();
    end
endmodule